// File: doc/BRIEF.md
# 4PPM Receive Chip Synchronizer

This block takes a 4PPM infrared receive line sampled on a 48 MHz clock and recovers chip timing from it. It divides the clock by six to get 8 MHz chip slots and samples the line near the middle of each slot. Every transition on the line restarts the chip phase, so the sampling point follows the incoming stream.

A two-bit chip counter groups the samples into four-chip symbols. The counter starts at an arbitrary point. While the block is hunting, the last sixteen chips are compared with the preamble at every symbol boundary. On a mismatch the counter holds for one chip, which moves the symbol boundary one slot later. When the preamble matches, the block raises `locked`. From then on it emits one decoded dibit per symbol, with a one-cycle strobe.

A loopback select takes the receive input from the transmit serial line instead of the receive pin, so a local transmitter can feed the receiver. The receiver does not block simultaneous transmit.

Top module: `ppm4_rx_sync`

## Requirements
- R1: While `rst_n` is low, `locked`, `sym_valid`, `sym_illegal` and `sym_dibit` are 0. One cycle after `enable` is seen low, `locked` and `sym_valid` are 0, and no symbol is emitted while `enable` stays low.
- R2: A chip slot is 6 clock cycles long. The line is sampled once per slot, in the third cycle of the slot, counted from the cycle in which a line change is first seen.
- R3: The chip phase restarts on every change of the line. A low slot stretched to 8 cycles before a rising edge produces no extra or lost chip.
- R4: Four consecutive chip samples form one symbol. The earliest chip is the leftmost bit of the 4-bit chip pattern.
- R5: Once four symbols have been collected since enable, and while unlocked, the last 16 chips are compared with the preamble 1000 0000 1010 1000 (earliest chip leftmost) at every symbol boundary. A mismatch makes the chip counter hold for one slot. A stream of legal data symbols alone never matches.
- R6: A preamble match sets `locked` in the next cycle. `locked` stays high until `enable` goes low. Sixteen preamble repetitions are enough to lock from any starting chip or sub-chip phase.
- R7: While locked, every symbol boundary gives a one-cycle `sym_valid` with the chip-to-dibit map 1000→0, 0100→1, 0010→2, 0001→3. The symbol that completes the match is not emitted.
- R8: A chip pattern that is not exactly one-hot is emitted with `sym_illegal`=1 and `sym_dibit`=0.
- R9: With `loopback`=1 the receive path uses `tx_line` and ignores `rx_line`. With `loopback`=0 it uses `rx_line`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz sample clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Receiver enable; low clears lock and symbol state |
| loopback | input | 1 | 1 selects the transmit serial line as receive input |
| rx_line | input | 1 | Receive line from the detector |
| tx_line | input | 1 | Transmit serial line, used in loopback |
| locked | output | 1 | Preamble found, symbol boundary aligned |
| sym_valid | output | 1 | One-cycle strobe per decoded symbol |
| sym_dibit | output | 2 | Decoded dibit |
| sym_illegal | output | 1 | Emitted symbol was not a one-hot chip pattern |

## Verification
The bench starts the preamble after a number of whole junk chips and idle cycles, so the counter has to slip a different number of times. A design that slipped wrongly, or compared at the wrong boundary, would never lock or would emit shifted dibits. A jitter case stretches low slots before rising edges. Without resynchronization the sampling point drifts a whole chip within a few pulses and the decoded data goes wrong. Further cases check that illegal chip patterns come out flagged with a zero dibit, that data without a preamble never locks, that loopback picks the right line, and that disabling drops lock and silences the output.

// File: rtl/ppm4_rx_sync.sv
module ppm4_rx_sync #(
  parameter int          DIV       = 6,
  parameter int          SAMPLE_AT = 2,
  parameter logic [15:0] PREAMBLE  = 16'h80A8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       loopback,
  input  logic       rx_line,
  input  logic       tx_line,
  output logic       locked,
  output logic       sym_valid,
  output logic [1:0] sym_dibit,
  output logic       sym_illegal
);
  localparam int PW = $clog2(DIV);

  logic          line_s, line_p;
  logic [PW-1:0] ph;
  logic [1:0]    cc;
  logic [15:0]   win;
  logic [2:0]    fill;
  logic          slip;

  wire           line_in   = loopback ? tx_line : rx_line;
  wire           edge_seen = line_s ^ line_p;
  wire [PW-1:0]  ph_eff    = edge_seen ? '0 : ph;
  wire           sample    = enable && (ph_eff == PW'(SAMPLE_AT));
  wire           boundary  = sample && !slip && (cc == 2'd3);
  wire [15:0]    win_n     = {win[14:0], line_s};
  wire           match     = (win_n == PREAMBLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_s <= 1'b0;
      line_p <= 1'b0;
      ph     <= '0;
    end else begin
      line_s <= line_in;
      line_p <= line_s;
      ph     <= (ph_eff == PW'(DIV - 1)) ? '0 : ph_eff + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      cc          <= '0;
      win         <= '0;
      fill        <= '0;
      slip        <= 1'b0;
      locked      <= 1'b0;
      sym_valid   <= 1'b0;
      sym_illegal <= 1'b0;
      sym_dibit   <= '0;
    end else begin
      sym_valid   <= 1'b0;
      sym_illegal <= 1'b0;
      if (sample) begin
        win <= win_n;
        if (slip) slip <= 1'b0;
        else      cc   <= cc + 1'b1;
      end
      if (boundary) begin
        if (fill != 3'd4) fill <= fill + 1'b1;
        if (locked) begin
          sym_valid <= 1'b1;
          case (win_n[3:0])
            4'b1000: sym_dibit <= 2'd0;
            4'b0100: sym_dibit <= 2'd1;
            4'b0010: sym_dibit <= 2'd2;
            4'b0001: sym_dibit <= 2'd3;
            default: begin
              sym_dibit   <= 2'd0;
              sym_illegal <= 1'b1;
            end
          endcase
        end else if (fill >= 3'd3) begin
          if (match) locked <= 1'b1;
          else       slip   <= 1'b1;
        end
      end
    end
  end

  p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ph <= PW'(DIV - 1));

  p_sample_spaced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> !sample);

  p_disable_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!locked && !sym_valid));

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && locked) |=> (!enable || locked));

  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> !sym_valid);

  p_valid_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> locked);

  p_illegal_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sym_illegal |-> (sym_valid && sym_dibit == 2'd0));
endmodule

// File: tb/ppm4_rx_sync_tb.sv
module ppm4_rx_sync_tb;
  localparam int CLK_PERIOD = 20;
  localparam int CHIP_CYC   = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       loopback = 1'b0;
  logic       rx_line = 1'b0;
  logic       tx_line = 1'b0;
  logic       locked, sym_valid, sym_illegal;
  logic [1:0] sym_dibit;

  int n_checks = 0;
  int n_fail   = 0;
  bit chips[$];
  int cap[$];
  int exp_c[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  ppm4_rx_sync u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .loopback(loopback),
    .rx_line(rx_line), .tx_line(tx_line), .locked(locked),
    .sym_valid(sym_valid), .sym_dibit(sym_dibit), .sym_illegal(sym_illegal)
  );

  always @(negedge clk) if (sym_valid) cap.push_back({29'd0, sym_illegal, sym_dibit});

  task automatic chk(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic add_sym(int d);
    for (int k = 0; k < 4; k++) chips.push_back(k == d);
    exp_c.push_back(d);
  endtask

  task automatic add_raw(logic [3:0] c, int code);
    for (int k = 3; k >= 0; k--) chips.push_back(c[k]);
    exp_c.push_back(code);
  endtask

  task automatic add_pre(int reps);
    for (int r = 0; r < reps; r++)
      for (int k = 15; k >= 0; k--) chips.push_back(k == 15 || k == 7 || k == 5 || k == 3);
  endtask

  task automatic play(bit stretch, bit via_tx);
    for (int i = 0; i < chips.size(); i++) begin
      int n;
      n = CHIP_CYC;
      if (stretch && !chips[i] && i + 1 < chips.size() && chips[i+1]) n = CHIP_CYC + 2;
      if (via_tx) tx_line = chips[i];
      else        rx_line = chips[i];
      repeat (n) @(negedge clk);
    end
    chips.delete();
  endtask

  task automatic restart();
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(!locked && !sym_valid, "R1 disable clears", {locked, sym_valid}, 0);
    rx_line = 1'b0;
    tx_line = 1'b0;
    repeat (8) @(negedge clk);
    cap.delete();
    exp_c.delete();
    enable = 1'b1;
  endtask

  // expected codes in exp_c, then one preamble: 0, illegal, illegal, 0
  task automatic check_tail(string req);
    int n, base;
    repeat (3) @(negedge clk);
    exp_c.push_back(0); exp_c.push_back(4); exp_c.push_back(4); exp_c.push_back(0);
    n = exp_c.size();
    chk(cap.size() >= n, req, cap.size(), n);
    if (cap.size() >= n) begin
      base = cap.size() - n;
      for (int j = 0; j < n; j++) chk(cap[base+j] == exp_c[j], req, cap[base+j], exp_c[j]);
    end
  endtask

  task automatic t_reset();
    chk(locked == 0 && sym_valid == 0 && sym_illegal == 0 && sym_dibit == 0,
        "R1 reset outputs", {locked, sym_valid, sym_illegal, sym_dibit}, 0);
  endtask

  task automatic t_lock(int zchips, int delay, int junk);
    restart();
    repeat (delay) @(negedge clk);
    for (int i = 0; i < zchips; i++) chips.push_back(1'b0);
    for (int i = 0; i < junk; i++) add_sym((i * 3 + 1) % 4);
    play(0, 0);
    chk(!locked, "R5 no lock before preamble", locked, 0);
    exp_c.delete();
    add_pre(16);
    play(0, 0);
    chk(locked, "R6 lock after preamble", locked, 1);
    for (int i = 0; i < 8; i++) add_sym((i * 5 + zchips) % 4);
    add_pre(1);
    play(0, 0);
    check_tail("R7 R2 R4 decoded data");
  endtask

  task automatic t_illegal();
    restart();
    add_pre(16);
    play(0, 0);
    exp_c.delete();
    add_raw(4'b1100, 4); add_raw(4'b0000, 4); add_sym(3); add_raw(4'b0110, 4); add_sym(2);
    add_pre(1);
    play(0, 0);
    check_tail("R8 illegal symbols");
  endtask

  task automatic t_no_lock();
    restart();
    for (int i = 0; i < 60; i++) add_sym((i * 7 + 2) % 4);
    play(0, 0);
    chk(!locked, "R5 data alone never locks", locked, 0);
    chk(cap.size() == 0, "R7 nothing emitted unlocked", cap.size(), 0);
  endtask

  task automatic t_jitter();
    restart();
    add_pre(16);
    play(1, 0);
    chk(locked, "R3 lock with stretched slots", locked, 1);
    exp_c.delete();
    for (int i = 0; i < 12; i++) add_sym((i % 2) ? 0 : 3);
    add_pre(1);
    play(1, 0);
    check_tail("R3 resync on edges");
  endtask

  task automatic t_loopback();
    restart();
    loopback = 1'b1;
    rx_line  = 1'b1;
    add_pre(16);
    play(0, 1);
    chk(locked, "R9 loopback lock", locked, 1);
    exp_c.delete();
    add_sym(1); add_sym(2); add_sym(0); add_sym(3);
    add_pre(1);
    play(0, 1);
    check_tail("R9 loopback data");
    loopback = 1'b0;
    restart();
    add_pre(16);
    play(0, 1);
    chk(!locked, "R9 tx ignored without loopback", locked, 0);
  endtask

  task automatic t_disable();
    restart();
    add_pre(16);
    play(0, 0);
    chk(locked, "R6 lock before disable", locked, 1);
    @(negedge clk);
    enable = 1'b0;
    cap.delete();
    add_pre(2);
    for (int i = 0; i < 4; i++) add_sym(i);
    play(0, 0);
    chk(!locked, "R1 lock cleared", locked, 0);
    chk(cap.size() == 0, "R1 no output while disabled", cap.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_lock(0, 0, 4);
    t_lock(1, 3, 5);
    t_lock(3, 5, 6);
    t_lock(2, 1, 9);
    t_illegal();
    t_no_lock();
    t_jitter();
    t_loopback();
    t_disable();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule